// File: doc/BRIEF.md
# FIFO Threshold Offset Register Loader

This block holds the two threshold offsets of a FIFO: the low-water offset, used for the near-empty flag, and the high-water offset, used for the near-full flag. It sits beside the FIFO storage and shares the FIFO's control pins. While the configuration select is high, those pins act on the offset registers instead of the data path.

The offsets can be loaded in two ways:
- **Serial:** one bit per clock from a single serial input. The low-water offset is filled first, least significant bit first. The high-water offset follows in the same order.
- **Parallel:** from the write data bus. Successive writes alternate between the low-water and the high-water register.

Parallel reads return the offsets on the read-back bus, low-water first and then high-water. Each of the three access kinds has its own sequencer. Reset returns every sequencer to the low-water position and loads both offsets with parameterised defaults.

Top module: `ofs_loader`

## Requirements
- R1: While `rst_n` is low, `empty_ofs` and `full_ofs` take `EMPTY_RST` and `FULL_RST` (default 127) and `rd_data` is zero. All three sequencers return to the low-water position.
- R2: A cycle with `cfg_sel` and `ser_en` both high is a serial shift. For the first W shifts after reset, each shift stores `ser_din` into `empty_ofs`, from bit 0 up to bit W-1, one bit per shift.
- R3: Shifts W+1 through 2W store `ser_din` into `full_ofs`, from bit 0 up to bit W-1. The next shift wraps back to bit 0 of `empty_ofs`.
- R4: A cycle with `cfg_sel` and `wr_en` high and `ser_en` low is a parallel write of `wr_data[W-1:0]`. The first parallel write after reset updates `empty_ofs` and the second updates `full_ofs`. Later writes keep alternating, and the other offset is unchanged.
- R5: A cycle with `cfg_sel` and `rd_en` high is a parallel read. On the next clock, `rd_data` shows an offset zero-extended to DW bits: `empty_ofs` for the first read after reset, `full_ofs` for the second, and alternating from then on.
- R6: While `cfg_sel` is low, `wr_en`, `rd_en`, `ser_en`, `ser_din` and `wr_data` leave `empty_ofs`, `full_ofs`, `rd_data` and all sequencers unchanged.
- R7: When a serial shift and a parallel write request fall in the same cycle, the serial shift is performed. The parallel write is dropped and the write sequencer does not advance.
- R8: A parallel read returns the offset value held before the clock edge, even when a write to that offset occurs in the same cycle. `rd_data` holds its value in cycles without a parallel read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by write and read side of the offset registers |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sel | input | 1 | Steers enables to the offset registers when high |
| ser_en | input | 1 | Serial shift enable |
| ser_din | input | 1 | Serial data bit |
| wr_en | input | 1 | Write enable (parallel offset write when `cfg_sel` is high) |
| rd_en | input | 1 | Read enable (parallel offset read when `cfg_sel` is high) |
| wr_data | input | DW (16) | Parallel write data |
| empty_ofs | output | W (15) | Low-water offset register |
| full_ofs | output | W (15) | High-water offset register |
| rd_data | output | DW (16) | Registered read-back data |

## Verification
The fault most likely to hide is a wrong sequencer position. A misplaced serial counter puts one bit at the wrong place in either offset on the very next clock. A write or read pointer that has not been reset, or that has advanced when it should not, sends the next parallel access to the other register. That error shows at `empty_ofs`, `full_ofs` or `rd_data` one clock after the access. A leaking enable while the configuration select is low changes an offset, or the read-back value, within one clock.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

  typedef enum logic {
    SEL_EMPTY = 1'b0,
    SEL_FULL  = 1'b1
  } ofs_sel_e;

  // next position of a serial counter that walks 0 .. total-1 and wraps
  function automatic int unsigned ser_next(input int unsigned cnt, input int unsigned total);
    if (cnt + 1 >= total) return 0;
    return cnt + 1;
  endfunction

  // which register a serial position belongs to
  function automatic ofs_sel_e ser_target(input int unsigned cnt, input int unsigned width);
    return (cnt >= width) ? SEL_FULL : SEL_EMPTY;
  endfunction

  // bit position inside the targeted register
  function automatic int unsigned ser_bit(input int unsigned cnt, input int unsigned width);
    return (cnt >= width) ? cnt - width : cnt;
  endfunction

endpackage

// File: rtl/ofs_ser_seq.sv
module ofs_ser_seq
  import ofs_pkg::*;
#(
  parameter int W = 15
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          shift,
  output logic [$clog2(2*W)-1:0]        cnt,
  output ofs_sel_e                      tgt,
  output logic [$clog2(W)-1:0]          idx
);

  localparam int TOTAL = 2 * W;
  localparam int CW    = $clog2(TOTAL);
  localparam int IW    = $clog2(W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (shift) begin
      cnt <= CW'(ser_next(int'(cnt), TOTAL));
    end
  end

  always_comb begin
    tgt = ser_target(int'(cnt), W);
    idx = IW'(ser_bit(int'(cnt), W));
  end

endmodule

// File: rtl/ofs_ptr.sv
module ofs_ptr
  import ofs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     adv,
  output ofs_sel_e sel
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel <= SEL_EMPTY;
    end else if (adv) begin
      sel <= (sel == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
    end
  end

endmodule

// File: rtl/ofs_bank.sv
module ofs_bank
  import ofs_pkg::*;
#(
  parameter int           W         = 15,
  parameter logic [W-1:0] EMPTY_RST = W'(127),
  parameter logic [W-1:0] FULL_RST  = W'(127)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_shift,
  input  ofs_sel_e             ser_tgt,
  input  logic [$clog2(W)-1:0] ser_idx,
  input  logic                 ser_bit,
  input  logic                 par_wr,
  input  ofs_sel_e             par_tgt,
  input  logic [W-1:0]         par_data,
  output logic [W-1:0]         empty_q,
  output logic [W-1:0]         full_q
);

  // one register per target, built from the same template
  for (genvar g = 0; g < 2; g++) begin : g_reg
    localparam ofs_sel_e     ME  = (g == 0) ? SEL_EMPTY : SEL_FULL;
    localparam logic [W-1:0] RST = (g == 0) ? EMPTY_RST : FULL_RST;
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= RST;
      end else if (ser_shift && ser_tgt == ME) begin
        q[ser_idx] <= ser_bit;
      end else if (par_wr && par_tgt == ME) begin
        q <= par_data;
      end
    end
  end

  assign empty_q = g_reg[0].q;
  assign full_q  = g_reg[1].q;

endmodule

// File: rtl/ofs_loader.sv
module ofs_loader
  import ofs_pkg::*;
#(
  parameter int           W         = 15,
  parameter int           DW        = 16,
  parameter logic [W-1:0] EMPTY_RST = W'(127),
  parameter logic [W-1:0] FULL_RST  = W'(127)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_sel,
  input  logic          ser_en,
  input  logic          ser_din,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wr_data,
  output logic [W-1:0]  empty_ofs,
  output logic [W-1:0]  full_ofs,
  output logic [DW-1:0] rd_data
);

  localparam int CW = $clog2(2 * W);
  localparam int IW = $clog2(W);

  function automatic logic [DW-1:0] widen(input logic [W-1:0] v);
    logic [DW-1:0] t;
    t = '0;
    t[W-1:0] = v;
    return t;
  endfunction

  // named access events
  logic ser_shift;
  logic par_wr;
  logic par_rd;

  assign ser_shift = cfg_sel & ser_en;
  assign par_wr    = cfg_sel & wr_en & ~ser_en;
  assign par_rd    = cfg_sel & rd_en;

  logic [CW-1:0] ser_cnt;
  ofs_sel_e      ser_tgt;
  logic [IW-1:0] ser_idx;
  ofs_sel_e      wr_sel;
  ofs_sel_e      rd_sel;

  ofs_ser_seq #(.W(W)) u_ser (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (ser_shift),
    .cnt   (ser_cnt),
    .tgt   (ser_tgt),
    .idx   (ser_idx)
  );

  ofs_ptr u_wptr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (par_wr),
    .sel   (wr_sel)
  );

  ofs_ptr u_rptr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (par_rd),
    .sel   (rd_sel)
  );

  ofs_bank #(
    .W         (W),
    .EMPTY_RST (EMPTY_RST),
    .FULL_RST  (FULL_RST)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_shift (ser_shift),
    .ser_tgt   (ser_tgt),
    .ser_idx   (ser_idx),
    .ser_bit   (ser_din),
    .par_wr    (par_wr),
    .par_tgt   (wr_sel),
    .par_data  (wr_data[W-1:0]),
    .empty_q   (empty_ofs),
    .full_q    (full_ofs)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (par_rd) begin
      rd_data <= widen((rd_sel == SEL_EMPTY) ? empty_ofs : full_ofs);
    end
  end

endmodule

// File: rtl/ofs_loader_chk.sv
module ofs_loader_chk
  import ofs_pkg::*;
#(
  parameter int W  = 15,
  parameter int DW = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_sel,
  input logic                   wr_en,
  input logic [DW-1:0]          wr_data,
  input logic [W-1:0]           empty_ofs,
  input logic [W-1:0]           full_ofs,
  input logic [DW-1:0]          rd_data,
  input logic                   ser_shift,
  input logic                   par_wr,
  input logic                   par_rd,
  input logic [$clog2(2*W)-1:0] ser_cnt,
  input ofs_sel_e               wr_sel,
  input ofs_sel_e               rd_sel
);

  localparam int TOTAL = 2 * W;

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_sel |=> $stable(empty_ofs) && $stable(full_ofs) && $stable(rd_data));

  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !par_rd |=> $stable(rd_data));

  p_par_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (par_wr && wr_sel == SEL_EMPTY) |=> (empty_ofs == $past(wr_data[W-1:0])) && $stable(full_ofs));

  p_par_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (par_wr && wr_sel == SEL_FULL) |=> (full_ofs == $past(wr_data[W-1:0])) && $stable(empty_ofs));

  p_rd_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (par_rd && rd_sel == SEL_EMPTY) |=> rd_data[W-1:0] == $past(empty_ofs));

  p_rd_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (par_rd && rd_sel == SEL_FULL) |=> rd_data[W-1:0] == $past(full_ofs));

  p_ser_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ser_shift |=> int'(ser_cnt) == ser_next(int'($past(ser_cnt)), TOTAL));

  p_ser_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_shift && wr_en) |=> $stable(wr_sel));

endmodule

bind ofs_loader ofs_loader_chk #(.W(W), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_sel   (cfg_sel),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .empty_ofs (empty_ofs),
  .full_ofs  (full_ofs),
  .rd_data   (rd_data),
  .ser_shift (ser_shift),
  .par_wr    (par_wr),
  .par_rd    (par_rd),
  .ser_cnt   (ser_cnt),
  .wr_sel    (wr_sel),
  .rd_sel    (rd_sel)
);

// File: tb/ofs_loader_tb.sv
module ofs_loader_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W  = 15;
  localparam int DW = 16;
  localparam int NV = 11;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_sel, ser_en, ser_din, wr_en, rd_en;
  logic [DW-1:0] wr_data;
  logic [W-1:0]  empty_ofs, full_ofs;
  logic [DW-1:0] rd_data;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ofs_loader u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_sel   (cfg_sel),
    .ser_en    (ser_en),
    .ser_din   (ser_din),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wr_data   (wr_data),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs),
    .rd_data   (rd_data)
  );

  // {cfg, ser, sdin, wr, rd} data, expected empty, full, read-back
  localparam logic [66:0] VEC [NV] = '{
    {5'b10010, 16'h1234, 15'h1234, 15'h007F, 16'h0000}, // R4 first write -> empty
    {5'b10010, 16'h8ABC, 15'h1234, 15'h0ABC, 16'h0000}, // R4 second write -> full
    {5'b10001, 16'h0000, 15'h1234, 15'h0ABC, 16'h1234}, // R5 first read empty
    {5'b10001, 16'h0000, 15'h1234, 15'h0ABC, 16'h0ABC}, // R5 second read full
    {5'b01111, 16'hFFFF, 15'h1234, 15'h0ABC, 16'h0ABC}, // R6 no cfg: ignored
    {5'b10010, 16'h0055, 15'h0055, 15'h0ABC, 16'h0ABC}, // R4 wrap to empty
    {5'b10010, 16'h7FFF, 15'h0055, 15'h7FFF, 16'h0ABC}, // R4 full again
    {5'b10001, 16'h0000, 15'h0055, 15'h7FFF, 16'h0055}, // R5 read empty
    {5'b10011, 16'h0001, 15'h0001, 15'h7FFF, 16'h7FFF}, // R8 read full, write empty
    {5'b11010, 16'h2222, 15'h0000, 15'h7FFF, 16'h7FFF}, // R7 serial wins, bit0 <- 0
    {5'b10010, 16'h0333, 15'h0000, 15'h0333, 16'h7FFF}  // R7 write ptr not advanced
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic idle();
    cfg_sel = 0; ser_en = 0; ser_din = 0; wr_en = 0; rd_en = 0; wr_data = '0;
  endtask

  task automatic step(input logic c, input logic s, input logic sd, input logic w,
                      input logic r, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_sel = c; ser_en = s; ser_din = sd; wr_en = w; rd_en = r; wr_data = d;
    @(posedge clk);
    #1;
    idle();
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] pe, pf;
    idle();
    rst_n = 0;
    do_reset();
    #1;
    check("R1 empty reset", 32'(empty_ofs), 32'h7F);
    check("R1 full reset", 32'(full_ofs), 32'h7F);
    check("R1 rd reset", 32'(rd_data), 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [66:0] v;
      v = VEC[i];
      step(v[66], v[65], v[64], v[63], v[62], v[61:46]);
      check($sformatf("R4-7 vec%0d empty", i), 32'(empty_ofs), 32'(v[45:31]));
      check($sformatf("R4-7 vec%0d full", i), 32'(full_ofs), 32'(v[30:16]));
      check($sformatf("R5/R8 vec%0d rd", i), 32'(rd_data), 32'(v[15:0]));
    end

    // R1: reset mid-sequence returns pointers to the empty side
    do_reset();
    step(1, 0, 0, 1, 0, 16'h0101);
    check("R1 wptr reset", 32'(empty_ofs), 32'h0101);
    check("R1 full untouched", 32'(full_ofs), 32'h7F);
    step(1, 0, 0, 0, 1, 16'h0);
    check("R1 rptr reset", 32'(rd_data), 32'h0101);

    // R2/R3: serial load, serial counter reset to bit 0
    pe = 15'h2A5C;
    pf = 15'h1357;
    for (int b = 0; b < W; b++) step(1, 1, pe[b], 0, 0, 16'h0);
    check("R2 serial empty", 32'(empty_ofs), 32'(pe));
    check("R2 full not yet", 32'(full_ofs), 32'h7F);
    // R6: serial enable without cfg_sel is ignored
    step(0, 1, 1, 0, 0, 16'h0);
    check("R6 serial idle empty", 32'(empty_ofs), 32'(pe));
    check("R6 serial idle full", 32'(full_ofs), 32'h7F);
    for (int b = 0; b < W; b++) step(1, 1, pf[b], 0, 0, 16'h0);
    check("R3 serial full", 32'(full_ofs), 32'(pf));
    check("R3 empty kept", 32'(empty_ofs), 32'(pe));
    step(1, 1, 1, 0, 0, 16'h0);
    check("R3 serial wrap", 32'(empty_ofs), 32'(pe | 15'h0001));
    check("R3 wrap full kept", 32'(full_ofs), 32'(pf));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule